// File: doc/BRIEF.md
# CAN Error State and Interrupt Router

This block sits beside a CAN protocol engine and turns its raw error information into a status word, interrupt flags and two interrupt lines. It watches the transmit and receive error counters to derive the warning, passive and bus-off states. It latches single-cycle protocol error pulses into sticky status bits, and records mailbox completion events until software retires them.

Two flag words exist, one per interrupt line. The three state-entry flags (system sources) go into the flag word of the line picked by a steering bit in the mask register. Each mailbox event goes into the flag word of the line picked by that mailbox's bit in the level register. Each flag word also carries the number of the highest-numbered pending mailbox routed to it. Software clears flags and sticky bits by writing ones.

A line is driven high when its enable bit is set and at least one of its flags is both set and unmasked. Writes use a simple select code: 0 clears status bits, 1 clears flag word 0, 2 clears flag word 1, 3 loads the mask and 4 loads the level register.

Top module: `can_err_irq_router`

## Requirements
- R1: Status bit 16 (warning) is 1 exactly when the transmit or the receive counter is above 96, visible one cycle after the counters are applied.
- R2: Status bit 17 (passive) is 1 exactly when either counter is above 127, with the same one-cycle latency.
- R3: Status bit 18 (bus-off) is 1 exactly when the transmit counter is 256 or more; the receive counter never causes bus-off.
- R4: A pulse on err_evt bit k (0 ack, 1 stuff, 2 CRC, 3 stuck-dominant, 4 bit, 5 form) sets status bit 19+k. The bit holds until a select-0 write has a 1 at that position. A new event in the same cycle as the clearing write wins. A zero in the write data leaves the bit alone.
- R5: Flag bits 8 (warning), 9 (passive) and 10 (bus-off) set only in the cycle the matching state is entered. Entering such a state again sets the flag again, but holding the state after the flag has been cleared leaves it clear. The flag goes into flag word 1 when mask bit 2 is 1 and into flag word 0 when it is 0.
- R6: Flag bits 8 to 10 clear when a 1 is written to them through that word's select (1 or 2). Writing 0 changes nothing.
- R7: A pulse on mbox_done[i] marks mailbox i pending. It is routed to line 1 when level bit i is 1 and to line 0 when it is 0. The routed word shows bit 15 set and bits 4:0 equal to the highest-numbered pending mailbox routed there.
- R8: Writing a 1 to bit 15 of a flag word retires only the mailbox shown in that word's bits 4:0. The next-highest pending mailbox is then reported, and bit 15 falls when none remain.
- R9: Line n (n = 0 or 1) is high exactly when mask bit n is 1 and either flag word n has bit 15 set, or one of its bits 8 to 10 is set together with the same mask bit.
- R10: After reset, status, both flag words, mask, level and both lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_cnt | input | 9 | Transmit error counter value |
| rx_err_cnt | input | 9 | Receive error counter value |
| err_evt | input | 6 | Protocol error pulses (ack, stuff, CRC, stuck, bit, form) |
| mbox_done | input | 32 | Per-mailbox completion pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| status | output | 32 | Error status word |
| flag0 | output | 32 | Flag word for line 0 |
| flag1 | output | 32 | Flag word for line 1 |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
The counter sweep crosses both counters over values on each side of 96, 127 and 256. A design with an off-by-one threshold, or one that lets the receive counter cause bus-off, shows a wrong status bit there. After each entry the bench clears the flags while the state still holds. A design that sets state flags on the level instead of the entry would set them again at once. The mailbox tests queue several mailboxes on one line and retire them one at a time. A design that drops all pending mailboxes at once, or reports the lowest, shows the wrong number. All 64 mask patterns are swept against fixed flags to catch a line that ignores its enable, its source mask or its steering.

// File: rtl/can_err_pkg.sv
// Shared constants and types for the CAN error state and interrupt router.
// Bit positions here are decoded by software, so they are fixed.
package can_err_pkg;
    localparam int ST_WARN_BIT  = 16;
    localparam int ST_PASS_BIT  = 17;
    localparam int ST_BOFF_BIT  = 18;
    localparam int ST_EVT_LSB   = 19;
    localparam int NUM_ERR_EVT  = 6;

    localparam int FL_SYS_LSB   = 8;
    localparam int FL_MBOX_BIT  = 15;
    localparam int FL_NUM_W     = 5;
    localparam int NUM_SYS      = 3;

    localparam int MK_SYS_TO_1  = 2;
    localparam int NUM_LINES    = 2;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_FLAG0  = 3'd1,
        SEL_FLAG1  = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_LEVEL  = 3'd4
    } wr_sel_e;

    typedef struct packed {
        logic boff;
        logic pass;
        logic warn;
    } err_state_t;
endpackage

// File: rtl/err_state_tracker.sv
// Derives warning, passive and bus-off levels from the error counters.
// Registers the levels and reports, combinationally, which states are being
// entered at the coming edge. Assumes the counters are stable synchronous values.
module err_state_tracker
    import can_err_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIMIT  = 96,
    parameter int PASS_LIMIT  = 127,
    parameter int BOFF_LIMIT  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output err_state_t       state_q,
    output err_state_t       entering
);
    localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LIMIT);
    localparam logic [CNT_W:0] PASS_V = (CNT_W+1)'(PASS_LIMIT);
    localparam logic [CNT_W:0] BOFF_V = (CNT_W+1)'(BOFF_LIMIT);

    err_state_t state_d;

    // Compare both counters against the thresholds.
    always_comb begin
        state_d.warn = ({1'b0, tx_cnt} > WARN_V) || ({1'b0, rx_cnt} > WARN_V);
        state_d.pass = ({1'b0, tx_cnt} > PASS_V) || ({1'b0, rx_cnt} > PASS_V);
        state_d.boff = ({1'b0, tx_cnt} >= BOFF_V);
        entering     = state_d & ~state_q;
    end

    // Hold the state levels for the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Bus-off needs a counter far above the passive threshold (R3).
    assert_boff_implies_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.boff |-> (state_q.pass && state_q.warn));
endmodule

// File: rtl/sticky_err_bits.sv
// Captures single-cycle protocol error pulses into sticky bits.
// Bits clear on write-one; a pulse in the same cycle as the clear wins.
module sticky_err_bits #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] bits_q
);
    logic [N-1:0] clr_eff;

    // Gate the clear mask with its strobe.
    always_comb clr_eff = clr_en ? clr_mask : '0;

    // Accumulate events, drop cleared bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q & ~clr_eff) | evt;
    end

    // A bit only rises when its event was seen (R4).
    assert_set_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bits_q & ~$past(bits_q) & ~$past(evt)) == '0));
endmodule

// File: rtl/sys_flag_line.sv
// Holds the three state-entry flags of one interrupt line.
// Sets win over write-one clears in the same cycle.
module sys_flag_line #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag_q
);
    // Update the flags from entries and clears.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= '0;
        else if (clr_en) flag_q <= (flag_q & ~clr_mask) | set;
        else             flag_q <= flag_q | set;
    end

    // A flag rises only with an entry pulse (R5).
    assert_flag_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(set)) == '0));
endmodule

// File: rtl/mbox_pend_tracker.sv
// Keeps one pending bit per mailbox and, for each line, reports the
// highest-numbered pending mailbox routed to it. A retire request clears only
// the mailbox currently reported on that line. Assumes NUM_MBOX <= 32.
module mbox_pend_tracker
    import can_err_pkg::*;
#(
    parameter int NUM_MBOX = 32,
    parameter int NUM_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_MBOX-1:0]             done,
    input  logic [NUM_MBOX-1:0]             to_line1,
    input  logic [NUM_LINES-1:0]            retire,
    output logic [NUM_LINES-1:0]            any,
    output logic [NUM_LINES-1:0][NUM_W-1:0] num,
    output logic [NUM_MBOX-1:0]             pend_q
);
    logic [NUM_LINES-1:0][NUM_MBOX-1:0] clr_line;
    logic [NUM_MBOX-1:0]                clr_all;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [NUM_MBOX-1:0] cand;

        // Select the pending mailboxes routed to this line.
        always_comb cand = pend_q & ((l == 1) ? to_line1 : ~to_line1);

        // Find the highest-numbered candidate.
        always_comb begin
            any[l] = 1'b0;
            num[l] = '0;
            for (int i = 0; i < NUM_MBOX; i++) begin
                if (cand[i]) begin
                    any[l] = 1'b1;
                    num[l] = NUM_W'(i);
                end
            end
        end

        // Build the one-hot retire mask for this line.
        always_comb begin
            clr_line[l] = '0;
            if (retire[l] && any[l]) clr_line[l][num[l]] = 1'b1;
        end

        // The reported mailbox is really pending (R7).
        assert_report_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
            any[l] |-> pend_q[num[l]]);
    end

    // Merge the retire masks of both lines.
    always_comb clr_all = clr_line[0] | clr_line[1];

    // Track pending mailboxes; a new event beats a retire.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_all) | done;
    end

    // A pending bit only falls after a retire request (R8).
    assert_retire_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q) != '0) |-> $past(|retire));

    // At most one mailbox leaves per retire per cycle (R8).
    assert_single_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(pend_q) & ~pend_q) <= 2);
endmodule

// File: rtl/can_err_irq_router.sv
// Top of the CAN error state and interrupt router. Assembles the status
// word and two flag words, holds the mask and level registers and drives
// two interrupt lines. Assumes NUM_MBOX <= 32 and single-cycle event pulses.
module can_err_irq_router
    import can_err_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int NUM_MBOX   = 32,
    parameter int WARN_LIMIT = 96,
    parameter int PASS_LIMIT = 127,
    parameter int BOFF_LIMIT = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    tx_err_cnt,
    input  logic [CNT_W-1:0]    rx_err_cnt,
    input  logic [5:0]          err_evt,
    input  logic [NUM_MBOX-1:0] mbox_done,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [31:0]         wr_data,
    output logic [31:0]         status,
    output logic [31:0]         flag0,
    output logic [31:0]         flag1,
    output logic                irq0,
    output logic                irq1
);
    localparam int NUM_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;
    localparam logic [31:0] MASK_IMPL = 32'h0000_0707;

    err_state_t                         state_q;
    err_state_t                         entering;
    logic [NUM_ERR_EVT-1:0]             sticky_q;
    logic [31:0]                        mask_q;
    logic [NUM_MBOX-1:0]                level_q;
    logic [NUM_LINES-1:0][NUM_SYS-1:0]  sys_q;
    logic [NUM_LINES-1:0]               mb_any;
    logic [NUM_LINES-1:0][NUM_W-1:0]    mb_num;
    logic [NUM_MBOX-1:0]                mb_pend;
    logic [NUM_LINES-1:0]               retire;
    logic [NUM_LINES-1:0][31:0]         flag_w;
    logic [NUM_LINES-1:0]               irq_w;
    wr_sel_e                            sel;

    // Decode the write select.
    always_comb sel = wr_sel_e'(wr_sel);

    err_state_tracker #(
        .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT),
        .PASS_LIMIT(PASS_LIMIT), .BOFF_LIMIT(BOFF_LIMIT)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
        .state_q(state_q), .entering(entering)
    );

    sticky_err_bits #(.N(NUM_ERR_EVT)) u_sticky (
        .clk(clk), .rst_n(rst_n), .evt(err_evt),
        .clr_en(wr_en && sel == SEL_STATUS),
        .clr_mask(wr_data[ST_EVT_LSB +: NUM_ERR_EVT]),
        .bits_q(sticky_q)
    );

    // Load the mask and level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
        end else if (wr_en && sel == SEL_MASK) begin
            mask_q  <= wr_data & MASK_IMPL;
        end else if (wr_en && sel == SEL_LEVEL) begin
            level_q <= wr_data[NUM_MBOX-1:0];
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic        steer_here;
        logic        clr_here;
        logic [31:0] word;

        // Decide whether system entries and this word's writes target this line.
        always_comb begin
            steer_here = (l == 1) ? mask_q[MK_SYS_TO_1] : ~mask_q[MK_SYS_TO_1];
            clr_here   = wr_en && (sel == ((l == 1) ? SEL_FLAG1 : SEL_FLAG0));
            retire[l]  = clr_here && wr_data[FL_MBOX_BIT];
        end

        sys_flag_line #(.N(NUM_SYS)) u_sys (
            .clk(clk), .rst_n(rst_n),
            .set(steer_here ? entering : err_state_t'('0)),
            .clr_en(clr_here),
            .clr_mask(wr_data[FL_SYS_LSB +: NUM_SYS]),
            .flag_q(sys_q[l])
        );

        // Assemble the flag word and the line output.
        always_comb begin
            word                          = '0;
            word[FL_SYS_LSB +: NUM_SYS]   = sys_q[l];
            word[FL_MBOX_BIT]             = mb_any[l];
            word[NUM_W-1:0]               = mb_num[l];
            flag_w[l]                     = word;
            irq_w[l] = mask_q[l] &&
                       (mb_any[l] || ((sys_q[l] & mask_q[FL_SYS_LSB +: NUM_SYS]) != '0));
        end

        // A raised line always has an enabled, flagged source (R9).
        assert_line_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_w[l] |-> (flag_w[l][FL_MBOX_BIT] ||
                          ((flag_w[l][FL_SYS_LSB +: NUM_SYS] & mask_q[FL_SYS_LSB +: NUM_SYS]) != '0)));
    end

    mbox_pend_tracker #(.NUM_MBOX(NUM_MBOX), .NUM_W(NUM_W)) u_mbox (
        .clk(clk), .rst_n(rst_n), .done(mbox_done), .to_line1(level_q),
        .retire(retire), .any(mb_any), .num(mb_num), .pend_q(mb_pend)
    );

    // Assemble the status word and drive the outputs.
    always_comb begin
        status                              = '0;
        status[ST_WARN_BIT]                 = state_q.warn;
        status[ST_PASS_BIT]                 = state_q.pass;
        status[ST_BOFF_BIT]                 = state_q.boff;
        status[ST_EVT_LSB +: NUM_ERR_EVT]   = sticky_q;
        flag0 = flag_w[0];
        flag1 = flag_w[1];
        irq0  = irq_w[0];
        irq1  = irq_w[1];
    end

    // Every pending mailbox is reported on exactly one line (R7).
    assert_pending_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_pend != '0) |-> (mb_any != '0));
endmodule

// File: tb/can_err_irq_router_test.sv
module can_err_irq_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  tx_err_cnt = '0;
    logic [8:0]  rx_err_cnt = '0;
    logic [5:0]  err_evt = '0;
    logic [31:0] mbox_done = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status, flag0, flag1;
    logic        irq0, irq1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_err_irq_router uut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .err_evt(err_evt), .mbox_done(mbox_done), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .flag0(flag0), .flag1(flag1),
        .irq0(irq0), .irq1(irq1)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_flags();
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int vals[8] = '{0, 96, 97, 127, 128, 255, 256, 300};
        logic [31:0] lvl;
        repeat (3) tick();
        // R10: reset state
        chk("R10 status", status, 32'h0);
        chk("R10 flag0", flag0, 32'h0);
        chk("R10 flag1", flag1, 32'h0);
        chk("R10 irq", {30'h0, irq1, irq0}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R1 R2 R3 R5 R6: counter threshold sweep
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic w, p, o;
                w = (vals[a] > 96) || (vals[b] > 96);
                p = (vals[a] > 127) || (vals[b] > 127);
                o = (vals[a] >= 256);
                tx_err_cnt = '0; rx_err_cnt = '0;
                tick();
                clear_flags();
                tx_err_cnt = 9'(vals[a]); rx_err_cnt = 9'(vals[b]);
                tick();
                chk("R1 R2 R3 state bits", {29'h0, status[18:16]}, {29'h0, o, p, w});
                chk("R5 entry flags in flag0", {29'h0, flag0[10:8]}, {29'h0, o, p, w});
                chk("R5 no flags in flag1", {29'h0, flag1[10:8]}, 32'h0);
                wr(3'd1, 32'h0);
                chk("R6 zero write keeps flags", {29'h0, flag0[10:8]}, {29'h0, o, p, w});
                wr(3'd1, 32'h0000_0700);
                tick();
                chk("R5 held state does not re-flag", {29'h0, flag0[10:8]}, 32'h0);
            end
        end

        // R5: steering of system flags to line 1
        tx_err_cnt = '0; rx_err_cnt = '0;
        wr(3'd3, 32'h4);
        tick();
        clear_flags();
        rx_err_cnt = 9'd200;
        tick();
        chk("R5 steered to flag1", {29'h0, flag1[10:8]}, 32'h3);
        chk("R5 flag0 untouched", {29'h0, flag0[10:8]}, 32'h0);
        rx_err_cnt = '0;
        wr(3'd3, 32'h0);
        clear_flags();

        // R4: sticky error bits sweep
        for (int pat = 0; pat < 64; pat++) begin
            err_evt = 6'(pat);
            tick();
            err_evt = '0;
            tick();
            chk("R4 sticky set", {26'h0, status[24:19]}, 32'(pat));
            wr(3'd0, 32'h0);
            chk("R4 zero write keeps", {26'h0, status[24:19]}, 32'(pat));
            wr(3'd0, 32'(pat) << 19);
            chk("R4 write-one clears", {26'h0, status[24:19]}, 32'h0);
        end
        err_evt = 6'h01;
        tick();
        err_evt = 6'h01;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0008_0000;
        tick();
        wr_en = 1'b0; err_evt = '0;
        chk("R4 event beats clear", {26'h0, status[24:19]}, 32'h1);
        wr(3'd0, 32'hFFFF_FFFF);

        // R7 R8: each mailbox routed by level pattern
        lvl = 32'hA5C3_0F69;
        wr(3'd4, lvl);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] mine, other;
            mbox_done = 32'h1 << i;
            tick();
            mbox_done = '0;
            mine  = lvl[i] ? flag1 : flag0;
            other = lvl[i] ? flag0 : flag1;
            chk("R7 routed event bit", {31'h0, mine[15]}, 32'h1);
            chk("R7 mailbox number", {27'h0, mine[4:0]}, 32'(i));
            chk("R7 other line idle", {31'h0, other[15]}, 32'h0);
            wr(lvl[i] ? 3'd2 : 3'd1, 32'h0000_8000);
            mine = lvl[i] ? flag1 : flag0;
            chk("R8 retired", {31'h0, mine[15]}, 32'h0);
        end

        // R6 R8: ordered retirement on one line
        wr(3'd4, 32'h0);
        mbox_done = (32'h1 << 3) | (32'h1 << 17) | (32'h1 << 30);
        tick();
        mbox_done = '0;
        chk("R7 highest first", {27'h0, flag0[4:0]}, 32'd30);
        wr(3'd1, 32'h0);
        chk("R6 zero write keeps mailbox", {27'h0, flag0[4:0]}, 32'd30);
        wr(3'd1, 32'h0000_8000);
        chk("R8 next is 17", {16'h0, flag0[15], 10'h0, flag0[4:0]}, 32'h0000_8011);
        wr(3'd1, 32'h0000_8000);
        chk("R8 next is 3", {16'h0, flag0[15], 10'h0, flag0[4:0]}, 32'h0000_8003);
        wr(3'd1, 32'h0000_8000);
        chk("R8 empty", {16'h0, flag0[15], 10'h0, flag0[4:0]}, 32'h0);

        // R9: line gating over all mask patterns
        clear_flags();
        wr(3'd4, 32'h0000_0020);
        tx_err_cnt = 9'd100;
        tick();
        mbox_done = 32'h0000_0020;
        tick();
        mbox_done = '0;
        for (int m = 0; m < 64; m++) begin
            logic [31:0] mv;
            logic e0, e1;
            mv = {21'h0, 3'(m >> 3), 5'h0, 3'(m)};
            wr(3'd3, mv);
            e0 = mv[0] & mv[8];
            e1 = mv[1];
            chk("R9 line0", {31'h0, irq0}, {31'h0, e0});
            chk("R9 line1", {31'h0, irq1}, {31'h0, e1});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule